// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a small clocked static memory whose read and write cycles can follow each other on every clock edge with no dead cycles between them. Address, control, byte-lane enables and write data are all captured on the rising clock edge. Write data is taken two edges after its address, which is the same pipeline slot in which read data leaves the array. Because of this alignment, a write that follows a read or a read that follows a write leaves no gap on the data bus.

A cycle is started by a load, which fixes the address and whether the cycle reads or writes. Further cycles can then be issued as a burst without a new address. An internal two-bit counter produces the low address bits in either sequential or interleaved order, and the read or write type stays the one fixed at the load. An active-low clock enable freezes the whole pipeline. An asynchronous output enable and a sleep input mask the registered output. Sleep also blocks new accesses.

Top module: `zt_sram`

## Requirements
- R1: After reset, dataValid is low. A read loaded at rising edge k places the word stored at its address on dataOut, with dataValid high, from just after edge k+2 until the next enabled edge.
- R2: While clkEnN is high, a rising edge changes no state. Every input is ignored for that edge, and dataOut and dataValid keep their values.
- R3: A load takes place when advLd is low, the device is selected and sleep is low. rdWrN low makes the cycle a write and rdWrN high makes it a read. A write's data is sampled on dataIn at the second enabled edge after its address and committed at that edge.
- R4: With advLd high after a load, each enabled edge issues one further cycle of the same type as the load, and rdWrN is ignored. After a deselecting load, advLd high issues nothing.
- R5: With burstIlv low (sequential order), beat n of a burst (the load is beat 0) uses address bits [1:0] = (loaded bits + n) mod 4. The upper address bits stay as loaded.
- R6: With burstIlv high (interleaved order), beat n uses address bits [1:0] = loaded bits XOR (n mod 4).
- R7: laneEn is active high and sampled together with the address of each cycle. On a write, bit i allows bits 8i+7..8i of the word to change, and lanes whose bit is low keep their stored contents.
- R8: A load with selN high, selHi low or selAltN high is a deselect. It produces no output slot: dataValid is low two edges later.
- R9: Reads and writes can alternate on every consecutive enabled edge. A read loaded on the edge right after a write to the same address returns the newly written lanes.
- R10: While outEnN is high or sleep is high, dataValid is low and dataOut is zero. A load or advance presented while sleep is high issues no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of the pipeline registers |
| clkEnN | input | 1 | Active-low clock enable; high freezes the pipeline |
| advLd | input | 1 | Low: load new address; high: advance burst |
| rdWrN | input | 1 | Read (high) or write (low), used at load only |
| selN | input | 1 | Active-low chip select |
| selHi | input | 1 | Active-high chip select |
| selAltN | input | 1 | Second active-low chip select |
| laneEn | input | 4 | Per-byte write enables, active high |
| addr | input | 4 | Word address |
| dataIn | input | 32 | Write data, taken two edges after its address |
| burstIlv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| outEnN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Blocks new accesses and masks the output |
| dataOut | output | 32 | Registered read data, zero when not valid |
| dataValid | output | 1 | Read data on dataOut is valid |

## Verification
The hardest cases are the ones where the two-edge delay of write data meets other events. Examples are a burst whose beats straddle clock-enable stalls, and a read loaded one edge after a write to the same word while that write's data has not yet been committed. The bench runs an independent pipelined model that holds each issued cycle's data until its commit slot. It sweeps every start value of the low address bits in both burst orders, every lane mask, and alternating read/write streams with stalls inserted at regular positions. Each output slot is compared on every cycle, so a misaligned or lost cycle is seen at once.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int ADDR_W  = 4;
  localparam int LANE_W  = 8;
  localparam int LANES   = 4;
  localparam int DATA_W  = LANE_W * LANES;
  localparam int BURST_W = 2;
  localparam int DEPTH   = 1 << ADDR_W;

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [LANES-1:0]  laneEn;
    logic [ADDR_W-1:0] addr;
  } slot_t;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advLd,
  input  logic              rdWrN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selAltN,
  input  logic [LANES-1:0]  laneEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burstIlv,
  input  logic              sleep,
  output slot_t             slotOut
);
  logic               active;
  logic               burstWrite;
  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] burstCnt;
  logic [BURST_W-1:0] nextCnt;
  logic [BURST_W-1:0] lowBits;
  logic               selected;
  slot_t              slotQ;

  always_comb begin
    selected = !selN && selHi && !selAltN;
    nextCnt  = burstCnt + 1'b1;
    if (burstIlv) lowBits = baseAddr[BURST_W-1:0] ^ nextCnt;
    else          lowBits = baseAddr[BURST_W-1:0] + nextCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      burstWrite <= 1'b0;
      baseAddr   <= '0;
      burstCnt   <= '0;
      slotQ      <= '0;
    end else if (!clkEnN) begin
      if (sleep) begin
        slotQ.valid <= 1'b0;
      end else if (!advLd) begin
        if (selected) begin
          active       <= 1'b1;
          burstWrite   <= !rdWrN;
          baseAddr     <= addr;
          burstCnt     <= '0;
          slotQ.valid  <= 1'b1;
          slotQ.write  <= !rdWrN;
          slotQ.laneEn <= laneEn;
          slotQ.addr   <= addr;
        end else begin
          active      <= 1'b0;
          slotQ.valid <= 1'b0;
        end
      end else if (active) begin
        burstCnt     <= nextCnt;
        slotQ.valid  <= 1'b1;
        slotQ.write  <= burstWrite;
        slotQ.laneEn <= laneEn;
        slotQ.addr   <= {baseAddr[ADDR_W-1:BURST_W], lowBits};
      end else begin
        slotQ.valid <= 1'b0;
      end
    end
  end

  assign slotOut = slotQ;

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN) clkEnN |=> $stable(slotQ)); // R2
  AST_LOAD_TYPE: assert property (@(posedge clk) disable iff (!rstN) (!clkEnN && !sleep && !advLd && selected) |=> (slotQ.valid && slotQ.write == !$past(rdWrN) && slotQ.addr == $past(addr))); // R3
  AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rstN) (!clkEnN && !sleep && advLd && active) |=> (slotQ.valid && slotQ.write == $past(burstWrite))); // R4
  AST_DESELECT_EMPTY: assert property (@(posedge clk) disable iff (!rstN) (!clkEnN && !sleep && !advLd && !selected) |=> !slotQ.valid); // R8
  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN) (!clkEnN && sleep) |=> !slotQ.valid); // R10
endmodule

// File: rtl/zt_sram_dpath.sv
module zt_sram_dpath
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  slot_t             slotIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;
  slot_t             slot2;
  logic              doWrite;
  logic              doRead;

  assign doWrite = slot2.valid && slot2.write;
  assign doRead  = slot2.valid && !slot2.write;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = slot2.laneEn[g] ? dataIn[g*LANE_W +: LANE_W]
                                                        : mem[slot2.addr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!clkEnN && doWrite) mem[slot2.addr] <= merged;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot2   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else if (!clkEnN) begin
      slot2   <= slotIn;
      rdValid <= doRead;
      if (doRead) rdData <= mem[slot2.addr];
    end
  end

  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rstN) (!clkEnN && slot2.valid && !slot2.write) |=> rdValid); // R1
  AST_NO_READ_OTHERWISE: assert property (@(posedge clk) disable iff (!rstN) (!clkEnN && !(slot2.valid && !slot2.write)) |=> !rdValid); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN) clkEnN |=> ($stable(rdValid) && $stable(rdData))); // R2
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advLd,
  input  logic              rdWrN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selAltN,
  input  logic [LANES-1:0]  laneEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              burstIlv,
  input  logic              outEnN,
  input  logic              sleep,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);
  slot_t             slot1;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;

  zt_sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLd(advLd), .rdWrN(rdWrN),
    .selN(selN), .selHi(selHi), .selAltN(selAltN), .laneEn(laneEn), .addr(addr),
    .burstIlv(burstIlv), .sleep(sleep), .slotOut(slot1)
  );

  zt_sram_dpath u_dpath (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .slotIn(slot1), .dataIn(dataIn),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign dataValid = rdValid && !outEnN && !sleep;
  assign dataOut   = dataValid ? rdData : '0;
endmodule

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0, advLd = 1'b0, rdWrN = 1'b1;
  logic        selN = 1'b1, selHi = 1'b1, selAltN = 1'b0;
  logic [3:0]  laneEn = 4'hF;
  logic [3:0]  addr = '0;
  logic [31:0] dataIn = '0;
  logic        burstIlv = 1'b0, outEnN = 1'b0, sleep = 1'b0;
  logic [31:0] dataOut;
  logic        dataValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  zt_sram u0 (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advLd(advLd), .rdWrN(rdWrN),
    .selN(selN), .selHi(selHi), .selAltN(selAltN), .laneEn(laneEn), .addr(addr),
    .dataIn(dataIn), .burstIlv(burstIlv), .outEnN(outEnN), .sleep(sleep),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  // Reference model
  logic [31:0] refMem [16];
  logic        p1v = 0, p1w = 0, p2v = 0, p2w = 0;
  logic [3:0]  p1a = 0, p2a = 0, p1be = 0, p2be = 0;
  logic [31:0] p1d = 0, p2d = 0;
  logic        mRdValid = 0;
  logic [31:0] mRdData = 0;
  logic        act = 0, bW = 0;
  logic [3:0]  bBase = 0;
  logic [1:0]  bCnt = 0;
  int          cyc = 0;

  // pending drive fields
  logic        gCeN = 0, gAdv = 1, gRw = 1, gSelN = 0, gSelHi = 1, gSelAltN = 0;
  logic [3:0]  gBe = 4'hF, gAddr = 0;
  logic [31:0] gWd = 0;
  logic        gOeN = 0, gSleep = 0, gIlv = 0;

  task automatic check(string tag);
    logic        expV;
    logic [31:0] expD;
    expV = mRdValid && !outEnN && !sleep;
    expD = expV ? mRdData : 32'h0;
    checks++;
    if (dataValid !== expV || dataOut !== expD) begin
      fails++;
      $display("FAIL %s: dataValid=%0b dataOut=%08h expected dataValid=%0b dataOut=%08h",
               tag, dataValid, dataOut, expV, expD);
    end
  endtask

  task automatic step(string tag);
    logic       selOk;
    logic [1:0] low;
    @(negedge clk);
    check(tag);
    clkEnN = gCeN; advLd = gAdv; rdWrN = gRw; selN = gSelN; selHi = gSelHi;
    selAltN = gSelAltN; laneEn = gBe; addr = gAddr; outEnN = gOeN; sleep = gSleep;
    burstIlv = gIlv;
    cyc++;
    if (gCeN || !(p2v && p2w)) dataIn = 32'h5A00_0000 ^ cyc;
    else                       dataIn = p2d;
    @(posedge clk);
    if (!clkEnN) begin
      mRdValid = p2v && !p2w;
      if (mRdValid) mRdData = refMem[p2a];
      if (p2v && p2w)
        for (int i = 0; i < 4; i++)
          if (p2be[i]) refMem[p2a][i*8 +: 8] = p2d[i*8 +: 8];
      p2v = p1v; p2w = p1w; p2a = p1a; p2be = p1be; p2d = p1d;
      selOk = !selN && selHi && !selAltN;
      if (sleep) p1v = 0;
      else if (!advLd) begin
        if (selOk) begin
          act = 1; bW = !rdWrN; bBase = addr; bCnt = 0;
          p1v = 1; p1w = bW; p1a = addr; p1be = laneEn; p1d = gWd;
        end else begin
          act = 0; p1v = 0;
        end
      end else if (act) begin
        bCnt = bCnt + 2'd1;
        low  = burstIlv ? (bBase[1:0] ^ bCnt) : (bBase[1:0] + bCnt);
        p1v = 1; p1w = bW; p1a = {bBase[3:2], low}; p1be = laneEn; p1d = gWd;
      end else p1v = 0;
    end
  endtask

  task automatic opLoad(string tag, logic wr, logic [3:0] a, logic [3:0] be, logic [31:0] wd);
    gCeN = 0; gAdv = 0; gRw = !wr; gSelN = 0; gSelHi = 1; gSelAltN = 0;
    gAddr = a; gBe = be; gWd = wd;
    step(tag);
  endtask

  task automatic opAdv(string tag, logic rwJunk, logic [3:0] be, logic [31:0] wd);
    gCeN = 0; gAdv = 1; gRw = rwJunk; gAddr = 4'(cyc); gBe = be; gWd = wd;
    step(tag);
  endtask

  task automatic opDesel(string tag, int which);
    gCeN = 0; gAdv = 0; gRw = cyc[0]; gAddr = 4'(cyc * 3);
    gSelN = (which == 0); gSelHi = (which != 1); gSelAltN = (which == 2);
    step(tag);
    gSelN = 0; gSelHi = 1; gSelAltN = 0;
  endtask

  task automatic opStall(string tag);
    gCeN = 1; gAdv = cyc[0]; gRw = cyc[1]; gAddr = 4'(cyc * 5); gBe = 4'(cyc); gWd = 32'hDEAD_0000;
    gSelN = cyc[2];
    step(tag);
    gSelN = 0;
  endtask

  task automatic flush(string tag);
    for (int i = 0; i < 3; i++) opDesel(tag, i);
  endtask

  function automatic logic [31:0] pat(int a, int salt);
    return (32'h0101_0101 * (a + 1)) ^ (32'h1357_9BDF * salt) ^ (a << 28);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dataValid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: dataValid=%0b expected 0", dataValid);
    end
    rstN = 1'b1;

    // R3/R1: fill every word back-to-back, then read it all back-to-back
    for (int a = 0; a < 16; a++) opLoad("R3 fill", 1, 4'(a), 4'hF, pat(a, 1));
    for (int a = 0; a < 16; a++) opLoad("R1 readback", 0, 4'(a), 4'hF, 0);
    flush("R1 drain");

    // R9: write then immediate read of the same word, every word, with stalls (R2)
    for (int a = 0; a < 16; a++) begin
      opLoad("R9 write", 1, 4'(a), 4'hF, pat(a, 2));
      if (a % 3 == 0) opStall("R2 stall mid-alternation");
      opLoad("R9 read-after-write", 0, 4'(a), 4'hF, 0);
      if (a % 4 == 1) begin opStall("R2 stall"); opStall("R2 stall"); end
    end
    flush("R9 drain");

    // R7: every lane mask on one word
    for (int m = 0; m < 16; m++) begin
      opLoad("R7 lane write", 1, 4'd5, 4'(m), pat(m, 7));
      opLoad("R7 lane read", 0, 4'd5, 4'hF, 0);
    end
    flush("R7 drain");

    // R4/R5/R6: bursts in both orders from every start value
    for (int md = 0; md < 2; md++) begin
      gIlv = md[0];
      for (int s = 0; s < 4; s++) begin
        opLoad(md ? "R6 write burst" : "R5 write burst", 1, 4'(8 + s), 4'hF, pat(s, 20 + md));
        for (int b = 1; b < 4; b++) begin
          opAdv("R4 write beat rdWrN ignored", 1, 4'hF, pat(s + b, 30 + md));
          if (b == 2) opStall("R2 stall in burst");
        end
        for (int a = 8; a < 12; a++) opLoad(md ? "R6 check" : "R5 check", 0, 4'(a), 4'hF, 0);
        opLoad(md ? "R6 read burst" : "R5 read burst", 0, 4'(4 + s), 4'hF, 0);
        for (int b = 1; b < 6; b++) opAdv("R4 read beat wraps", 0, 4'h0, pat(b, 99));
        flush("R4 drain");
      end
    end
    gIlv = 0;

    // R8: each deselect, then advance after deselect issues nothing
    for (int w = 0; w < 3; w++) begin
      opDesel("R8 deselect", w);
      opAdv("R8 advance after deselect", 0, 4'hF, 0);
      opAdv("R8 advance after deselect", 1, 4'hF, 32'hFFFF_FFFF);
    end
    flush("R8 drain");
    for (int a = 0; a < 4; a++) opLoad("R8 memory unchanged", 0, 4'(a), 4'hF, 0);
    flush("R8 drain");

    // R10: output enable masks, sleep masks and blocks loads
    gOeN = 1;
    for (int a = 0; a < 4; a++) opLoad("R10 oe off", 0, 4'(a), 4'hF, 0);
    gOeN = 0;
    flush("R10 drain");
    gSleep = 1;
    opLoad("R10 sleep write blocked", 1, 4'd2, 4'hF, 32'h0BAD_0BAD);
    opLoad("R10 sleep read blocked", 0, 4'd3, 4'hF, 0);
    opAdv("R10 sleep adv", 0, 4'hF, 0);
    gSleep = 0;
    flush("R10 drain");
    opLoad("R10 after sleep", 0, 4'd2, 4'hF, 0);
    opLoad("R10 mid-read sleep", 0, 4'd3, 4'hF, 0);
    opDesel("R10 drain", 0);
    gSleep = 1;
    opDesel("R10 masked by sleep", 1);
    gSleep = 0;
    flush("R10 drain");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule